// File: doc/BRIEF.md
# Serial Transport Overhead Insertion Port

The port takes overhead bytes for the transmit direction from an external three-wire serial channel: a bit clock, a frame sync and a data line. It rebuilds the bytes and checks a parity byte over them. Once per frame it hands a downstream overhead inserter a table of sixteen byte slots. Each slot carries an enable bit that says whether the slot holds serial data or a stuff value. The slots cover the two orderwire bytes, the user byte, the twelve data communication channel bytes and the sync-status byte. Two reduced modes carry only the section channel bytes (three per frame, the low-rate stream) or only the line channel bytes (nine per frame, the higher-rate stream).

All three serial wires are brought into the core clock through a synchronizer. A bit is taken on each rising edge of the serial clock. The frame table leaves the block on a valid/ready stream. `ovh_valid` rises when a frame completes and stays high, with the table unchanged, until the consumer accepts it with `ovh_ready`. There is no queue. A frame that completes while the previous one is still waiting replaces that one in place and `ovh_valid` stays high, so back-pressure never stalls the serial side. Two sticky flags report parity and alignment faults. Each flag clears with a one-cycle pulse on its clear input.

Top module: `ohp_serial_port`

## Requirements
- R1: Serial bits are taken MSB first, one per rising edge of `ser_clk`. `ser_sync` is high with the first bit of a frame. Bits that arrive before the first sync after reset are dropped and raise no flag.
- R2: With `cfg_mode`=0 (full), a frame is 16 data bytes followed by one parity byte. Data byte k goes to slot k, and slot i sits at `ovh_bytes[8*i+7:8*i]`. The slots are, in order: 0 first orderwire, 1 user byte, 2..4 section channel bytes, 5..13 line channel bytes, 14 sync status, 15 second orderwire.
- R3: With `cfg_mode`=1 (section channel only), a frame is 3 data bytes plus parity, written to slots 2..4. All other slots are stuffed.
- R4: With `cfg_mode`=2 (line channel only), a frame is 9 data bytes plus parity, written to slots 5..13. All other slots are stuffed.
- R5: The XOR of all data bytes and the parity byte must be 8'h00 when `cfg_par_odd`=0 and 8'hFF when it is 1. A mismatch sets `par_err`, and the frame is still published.
- R6: `par_err` stays set until a `par_err_clr` pulse. A new error in the same cycle wins over the clear.
- R7: A slot is enabled only when `cfg_slot_en[i]` is 1 and the slot is carried in the current mode. `ovh_en[i]` reports this. A slot that is not enabled reads 8'hFF when `cfg_stuff_ones`=1 and 8'h00 otherwise.
- R8: A sync at any bit other than the expected frame start sets `sync_err` and starts a new frame at that bit. The partial frame is discarded and never published.
- R9: Once aligned, a frame start without sync sets `sync_err` and drops alignment. Bits are then ignored until the next sync.
- R10: `sync_err` stays set until a `sync_err_clr` pulse. A new error wins over the clear.
- R11: `ovh_valid` rises after a frame's parity byte. While it is high and `ovh_ready` is low, `ovh_bytes` and `ovh_en` hold unless a newer frame replaces them. `ovh_valid` falls after a cycle with `ovh_ready` high and no new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | core clock |
| rst_n | input | 1 | asynchronous reset, active low |
| ser_clk | input | 1 | serial bit clock |
| ser_sync | input | 1 | frame sync, high with the first bit |
| ser_data | input | 1 | serial data |
| cfg_mode | input | 2 | 0 full, 1 section channel only, 2 line channel only |
| cfg_par_odd | input | 1 | 1 selects odd parity |
| cfg_stuff_ones | input | 1 | 1 stuffs 8'hFF, 0 stuffs 8'h00 |
| cfg_slot_en | input | 16 | per-slot insertion enable |
| par_err_clr | input | 1 | clears `par_err` |
| sync_err_clr | input | 1 | clears `sync_err` |
| ovh_valid | output | 1 | frame table is valid |
| ovh_ready | input | 1 | consumer accepts the table |
| ovh_bytes | output | 128 | slot bytes, slot i at bits 8i+7..8i |
| ovh_en | output | 16 | per-slot enable, 0 means stuffed |
| par_err | output | 1 | sticky parity error |
| sync_err | output | 1 | sticky alignment error |

## Verification
The bench sweeps every mode against both parity senses and both stuff values. It uses a dense enable pattern and a sparse one, and derives the slot bytes arithmetically from a per-frame seed. A slot mapped to the wrong index, a wrong window for a channel-only mode, or a wrong stuff polarity all show up as a byte or enable mismatch. Frames with a corrupted parity byte under each parity sense separate a real check from one that is fixed to a single sense. Separate patterns cover a sync placed mid-frame, a missing sync after alignment, bits before the first sync, and two frames published with no acceptance between them. Together these separate realignment, unlock, pre-lock silence and overwrite behaviour.

// File: rtl/ohp_pkg.sv
package ohp_pkg;

  localparam int unsigned NSLOT = 16;
  localparam int unsigned BW    = 8;

  typedef enum logic [1:0] {
    MODE_FULL = 2'd0,
    MODE_SDCC = 2'd1,
    MODE_LDCC = 2'd2
  } mode_e;

  // number of data bytes per frame (parity byte excluded)
  function automatic logic [4:0] data_len(input logic [1:0] m);
    case (m)
      MODE_SDCC: data_len = 5'd3;
      MODE_LDCC: data_len = 5'd9;
      default:   data_len = 5'd16;
    endcase
  endfunction

  // first slot written by serial byte 0
  function automatic logic [4:0] slot_base(input logic [1:0] m);
    case (m)
      MODE_SDCC: slot_base = 5'd2;
      MODE_LDCC: slot_base = 5'd5;
      default:   slot_base = 5'd0;
    endcase
  endfunction

  // slots that the serial stream fills in a mode
  function automatic logic [NSLOT-1:0] carried_mask(input logic [1:0] m);
    int b;
    int l;
    b = int'(slot_base(m));
    l = int'(data_len(m));
    for (int i = 0; i < int'(NSLOT); i++) begin
      carried_mask[i] = (i >= b) && (i < b + l);
    end
  endfunction

endpackage

// File: rtl/ohp_edge_sync.sv
module ohp_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ser_clk,
  input  logic ser_sync,
  input  logic ser_data,
  output logic rise,
  output logic smp_sync,
  output logic smp_data
);

  logic [STAGES-1:0] clk_q;
  logic [STAGES-1:0] syn_q;
  logic [STAGES-1:0] dat_q;
  logic              clk_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_q    <= '0;
      syn_q    <= '0;
      dat_q    <= '0;
      clk_prev <= 1'b0;
    end else begin
      clk_q    <= {clk_q[STAGES-2:0], ser_clk};
      syn_q    <= {syn_q[STAGES-2:0], ser_sync};
      dat_q    <= {dat_q[STAGES-2:0], ser_data};
      clk_prev <= clk_q[STAGES-1];
    end
  end

  assign rise     = clk_q[STAGES-1] & ~clk_prev;
  assign smp_sync = syn_q[STAGES-1];
  assign smp_data = dat_q[STAGES-1];

  // a detected edge needs the synchronized clock to have been low first
  p_rise_spaced_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);

endmodule

// File: rtl/ohp_deser.sv
module ohp_deser #(
  parameter int unsigned BW = 8,
  parameter int unsigned CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rise,
  input  logic          s_sync,
  input  logic          s_data,
  input  logic [CW-1:0] frame_len,
  output logic          byte_stb,
  output logic [BW-1:0] byte_val,
  output logic [CW-1:0] byte_idx,
  output logic          frame_start,
  output logic          sync_err_p
);

  localparam int unsigned BCW = $clog2(BW);

  logic           locked;
  logic [BCW-1:0] bit_cnt;
  logic [CW-1:0]  byte_cnt;
  logic [BW-1:0]  sh;
  logic [BW-1:0]  nxt;
  logic           at_start;

  assign nxt      = {sh[BW-2:0], s_data};
  assign at_start = (bit_cnt == '0) && (byte_cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked      <= 1'b0;
      bit_cnt     <= '0;
      byte_cnt    <= '0;
      sh          <= '0;
      byte_stb    <= 1'b0;
      byte_val    <= '0;
      byte_idx    <= '0;
      frame_start <= 1'b0;
      sync_err_p  <= 1'b0;
    end else begin
      byte_stb    <= 1'b0;
      frame_start <= 1'b0;
      sync_err_p  <= 1'b0;
      if (rise) begin
        if (s_sync) begin
          if (locked && !at_start) sync_err_p <= 1'b1;
          locked      <= 1'b1;
          frame_start <= 1'b1;
          bit_cnt     <= BCW'(1);
          byte_cnt    <= '0;
          sh          <= {{(BW-1){1'b0}}, s_data};
        end else if (locked) begin
          if (at_start) begin
            sync_err_p <= 1'b1;
            locked     <= 1'b0;
          end else begin
            sh <= nxt;
            if (bit_cnt == BCW'(BW-1)) begin
              byte_stb <= 1'b1;
              byte_val <= nxt;
              byte_idx <= byte_cnt;
              bit_cnt  <= '0;
              byte_cnt <= (byte_cnt == frame_len - CW'(1)) ? '0 : byte_cnt + CW'(1);
            end else begin
              bit_cnt <= bit_cnt + BCW'(1);
            end
          end
        end
      end
    end
  end

  p_stb_vs_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(byte_stb && frame_start));

  p_idx_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    byte_stb |-> (byte_idx < frame_len));

endmodule

// File: rtl/ohp_frame_asm.sv
module ohp_frame_asm
  import ohp_pkg::*;
#(
  parameter int unsigned NS = 16,
  parameter int unsigned BW = 8,
  parameter int unsigned CW = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [1:0]            mode,
  input  logic                  par_odd,
  input  logic                  stuff_ones,
  input  logic [NS-1:0]         slot_en,
  input  logic                  byte_stb,
  input  logic [BW-1:0]         byte_val,
  input  logic [CW-1:0]         byte_idx,
  input  logic                  frame_start,
  input  logic                  out_ready,
  output logic                  out_valid,
  output logic [NS-1:0][BW-1:0] out_bytes,
  output logic [NS-1:0]         out_en,
  output logic                  par_err_p
);

  localparam int unsigned SW = $clog2(NS);

  logic [NS-1:0][BW-1:0] cap;
  logic [BW-1:0]         acc;
  logic [CW-1:0]         dlen;
  logic [SW-1:0]         wr_slot;
  logic [NS-1:0]         carried;
  logic                  is_data;
  logic                  publish;
  logic                  par_ok;
  logic [BW-1:0]         stuff;

  assign dlen    = CW'(data_len(mode));
  assign wr_slot = SW'(slot_base(mode)) + SW'(byte_idx);
  assign carried = carried_mask(mode);
  assign is_data = byte_idx < dlen;
  assign publish = byte_stb && !is_data;
  assign par_ok  = ((acc ^ byte_val) == (par_odd ? {BW{1'b1}} : {BW{1'b0}}));
  assign stuff   = stuff_ones ? {BW{1'b1}} : {BW{1'b0}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap <= '0;
      acc <= '0;
    end else if (frame_start) begin
      acc <= '0;
    end else if (byte_stb) begin
      if (is_data) begin
        cap[wr_slot] <= byte_val;
        acc          <= acc ^ byte_val;
      end else begin
        acc <= '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_bytes <= '0;
      out_en    <= '0;
      par_err_p <= 1'b0;
    end else begin
      par_err_p <= publish && !par_ok;
      if (publish) begin
        out_valid <= 1'b1;
        for (int i = 0; i < int'(NS); i++) begin
          out_en[i]    <= slot_en[i] & carried[i];
          out_bytes[i] <= (slot_en[i] & carried[i]) ? cap[i] : stuff;
        end
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  p_hold_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !publish) |=> (out_valid && $stable(out_bytes) && $stable(out_en)));

  p_en_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_en & ~carried) == '0));

endmodule

// File: rtl/ohp_serial_port.sv
module ohp_serial_port
  import ohp_pkg::*;
#(
  parameter int unsigned NS          = ohp_pkg::NSLOT,
  parameter int unsigned BW          = ohp_pkg::BW,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_clk,
  input  logic             ser_sync,
  input  logic             ser_data,
  input  logic [1:0]       cfg_mode,
  input  logic             cfg_par_odd,
  input  logic             cfg_stuff_ones,
  input  logic [NS-1:0]    cfg_slot_en,
  input  logic             par_err_clr,
  input  logic             sync_err_clr,
  output logic             ovh_valid,
  input  logic             ovh_ready,
  output logic [NS*BW-1:0] ovh_bytes,
  output logic [NS-1:0]    ovh_en,
  output logic             par_err,
  output logic             sync_err
);

  localparam int unsigned CW = $clog2(NS + 2);

  logic                  rise;
  logic                  smp_sync;
  logic                  smp_data;
  logic [CW-1:0]         frame_len;
  logic                  byte_stb;
  logic [BW-1:0]         byte_val;
  logic [CW-1:0]         byte_idx;
  logic                  frame_start;
  logic                  sync_err_p;
  logic                  par_err_p;
  logic [NS-1:0][BW-1:0] tbl;

  assign frame_len = CW'(data_len(cfg_mode)) + CW'(1);

  ohp_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .ser_clk(ser_clk), .ser_sync(ser_sync), .ser_data(ser_data),
    .rise(rise), .smp_sync(smp_sync), .smp_data(smp_data)
  );

  ohp_deser #(.BW(BW), .CW(CW)) u_deser (
    .clk(clk), .rst_n(rst_n),
    .rise(rise), .s_sync(smp_sync), .s_data(smp_data),
    .frame_len(frame_len),
    .byte_stb(byte_stb), .byte_val(byte_val), .byte_idx(byte_idx),
    .frame_start(frame_start), .sync_err_p(sync_err_p)
  );

  ohp_frame_asm #(.NS(NS), .BW(BW), .CW(CW)) u_asm (
    .clk(clk), .rst_n(rst_n),
    .mode(cfg_mode), .par_odd(cfg_par_odd), .stuff_ones(cfg_stuff_ones),
    .slot_en(cfg_slot_en),
    .byte_stb(byte_stb), .byte_val(byte_val), .byte_idx(byte_idx),
    .frame_start(frame_start), .out_ready(ovh_ready),
    .out_valid(ovh_valid), .out_bytes(tbl), .out_en(ovh_en),
    .par_err_p(par_err_p)
  );

  assign ovh_bytes = tbl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      par_err  <= 1'b0;
      sync_err <= 1'b0;
    end else begin
      par_err  <= (par_err & ~par_err_clr) | par_err_p;
      sync_err <= (sync_err & ~sync_err_clr) | sync_err_p;
    end
  end

  p_par_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (par_err && !par_err_clr) |=> par_err);

  p_sync_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_err && !sync_err_clr) |=> sync_err);

endmodule

// File: tb/ohp_serial_port_bench.sv
`timescale 1ns/1ps
module ohp_serial_port_bench;

  localparam int NS = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ser_clk = 1'b1, ser_sync = 1'b0, ser_data = 1'b0;
  logic [1:0]    cfg_mode = 2'd0;
  logic          cfg_par_odd = 1'b0, cfg_stuff_ones = 1'b0;
  logic [NS-1:0] cfg_slot_en = '1;
  logic          par_err_clr = 1'b0, sync_err_clr = 1'b0;
  logic          ovh_valid, ovh_ready = 1'b0;
  logic [NS*8-1:0] ovh_bytes;
  logic [NS-1:0] ovh_en;
  logic          par_err, sync_err;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ohp_serial_port u_ohp_serial_port (
    .clk(clk), .rst_n(rst_n),
    .ser_clk(ser_clk), .ser_sync(ser_sync), .ser_data(ser_data),
    .cfg_mode(cfg_mode), .cfg_par_odd(cfg_par_odd), .cfg_stuff_ones(cfg_stuff_ones),
    .cfg_slot_en(cfg_slot_en), .par_err_clr(par_err_clr), .sync_err_clr(sync_err_clr),
    .ovh_valid(ovh_valid), .ovh_ready(ovh_ready), .ovh_bytes(ovh_bytes),
    .ovh_en(ovh_en), .par_err(par_err), .sync_err(sync_err)
  );

  task automatic chk(input bit ok, input string req, input logic [NS*8-1:0] act,
                     input logic [NS*8-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic int blen(input logic [1:0] m);
    return (m == 2'd1) ? 3 : (m == 2'd2) ? 9 : 16;
  endfunction
  function automatic int bbase(input logic [1:0] m);
    return (m == 2'd1) ? 2 : (m == 2'd2) ? 5 : 0;
  endfunction
  function automatic logic [7:0] gen(input int seed, input int k);
    return 8'((seed * 37 + k * 11 + 5) & 255);
  endfunction

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic d, input logic s);
    @(negedge clk);
    ser_clk = 1'b0; ser_data = d; ser_sync = s;
    idle(4);
    ser_clk = 1'b1;
    idle(4);
    ser_sync = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, input logic first);
    for (int j = 7; j >= 0; j--) send_bit(b[j], first && (j == 7));
  endtask

  // whole frame: data bytes, then parity byte (optionally corrupted)
  task automatic send_frame(input int seed, input bit corrupt);
    logic [7:0] acc;
    acc = 8'h00;
    for (int k = 0; k < blen(cfg_mode); k++) begin
      send_byte(gen(seed, k), k == 0);
      acc ^= gen(seed, k);
    end
    if (cfg_par_odd) acc = ~acc;
    if (corrupt) acc ^= 8'h10;
    send_byte(acc, 1'b0);
    idle(12);
  endtask

  task automatic expect_tbl(input int seed, input string req);
    logic [NS*8-1:0] eb;
    logic [NS-1:0]   ee;
    int b, l;
    b = bbase(cfg_mode); l = blen(cfg_mode);
    for (int i = 0; i < NS; i++) begin
      ee[i] = cfg_slot_en[i] && (i >= b) && (i < b + l);
      eb[i*8 +: 8] = ee[i] ? gen(seed, i - b) : (cfg_stuff_ones ? 8'hFF : 8'h00);
    end
    chk(ovh_valid === 1'b1, {req, " valid"}, {127'b0, ovh_valid}, 128'd1);
    chk(ovh_bytes === eb, {req, " bytes"}, ovh_bytes, eb);
    chk(ovh_en === ee, {req, " en"}, {112'b0, ovh_en}, {112'b0, ee});
  endtask

  task automatic accept();
    @(negedge clk); ovh_ready = 1'b1;
    @(negedge clk); ovh_ready = 1'b0;
    chk(ovh_valid === 1'b0, "R11 drop after accept", {127'b0, ovh_valid}, 128'd0);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    ser_clk = 1'b1; ser_sync = 1'b0; ser_data = 1'b0;
    idle(3); rst_n = 1'b1; idle(2);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 1;
    do_reset();
    chk(ovh_valid === 1'b0 && par_err === 1'b0 && sync_err === 1'b0,
        "reset state", {125'b0, ovh_valid, par_err, sync_err}, 128'd0);

    // R1: bits before first sync are silent
    send_byte(8'hA5, 1'b0); idle(12);
    chk(ovh_valid === 1'b0 && sync_err === 1'b0, "R1 pre-sync ignored",
        {126'b0, ovh_valid, sync_err}, 128'd0);

    // sweep: mode x parity sense x stuff polarity x enable pattern
    for (int m = 0; m < 3; m++) begin
      for (int p = 0; p < 2; p++) begin
        for (int s = 0; s < 2; s++) begin
          cfg_mode = 2'(m); cfg_par_odd = p[0]; cfg_stuff_ones = s[0];
          cfg_slot_en = '1;
          do_reset();
          send_frame(seed, 1'b0);
          expect_tbl(seed, m == 0 ? "R2,R7" : (m == 1 ? "R3,R7" : "R4,R7"));
          chk(par_err === 1'b0, "R5 good parity", {127'b0, par_err}, 128'd0);
          accept();
          seed++;
          cfg_slot_en = 16'(16'hA5C3 ^ (seed * 16'h0111));
          send_frame(seed, 1'b1);
          expect_tbl(seed, "R5,R7 bad parity still published");
          chk(par_err === 1'b1, "R5 parity mismatch flagged", {127'b0, par_err}, 128'd1);
          accept();
          seed++;
        end
      end
    end

    // R6: sticky parity flag and clear
    idle(5);
    chk(par_err === 1'b1, "R6 sticky", {127'b0, par_err}, 128'd1);
    @(negedge clk); par_err_clr = 1'b1; @(negedge clk); par_err_clr = 1'b0;
    chk(par_err === 1'b0, "R6 clear", {127'b0, par_err}, 128'd0);

    // R8: sync in the middle of a frame (full mode)
    cfg_mode = 2'd0; cfg_par_odd = 1'b0; cfg_stuff_ones = 1'b0; cfg_slot_en = '1;
    do_reset();
    for (int k = 0; k < 5; k++) send_byte(gen(seed, k), k == 0);
    idle(12);
    chk(ovh_valid === 1'b0 && sync_err === 1'b0, "R8 partial pending",
        {126'b0, ovh_valid, sync_err}, 128'd0);
    seed++;
    send_frame(seed, 1'b0);
    chk(sync_err === 1'b1, "R8 misplaced sync flagged", {127'b0, sync_err}, 128'd1);
    expect_tbl(seed, "R8 realigned frame");
    accept();

    // R10: sticky sync flag and clear
    @(negedge clk); sync_err_clr = 1'b1; @(negedge clk); sync_err_clr = 1'b0;
    chk(sync_err === 1'b0, "R10 clear", {127'b0, sync_err}, 128'd0);

    // R9: missing sync at frame start, then bits ignored
    send_byte(8'h3C, 1'b0); send_byte(8'hC3, 1'b0); idle(12);
    chk(sync_err === 1'b1 && ovh_valid === 1'b0, "R9 missing sync unlocks",
        {126'b0, sync_err, ovh_valid}, 128'd2);
    idle(4);
    chk(sync_err === 1'b1, "R10 sticky", {127'b0, sync_err}, 128'd1);
    seed++;
    send_frame(seed, 1'b0);
    expect_tbl(seed, "R9 relock on next sync");
    accept();

    // R11: two frames, no accept between; table holds then is replaced
    seed++;
    send_frame(seed, 1'b0);
    idle(40);
    expect_tbl(seed, "R11 held while not accepted");
    seed++;
    send_frame(seed, 1'b0);
    expect_tbl(seed, "R11 newer frame replaces");
    accept();

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule